// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Unit

This block derives two slow events from one clock-source tick stream. A single shared prescaler divides the incoming ticks by `2**PRE_W`. Its carry drives a periodic time-base pulse. The same carry also feeds a watchdog stage that divides by a further `2**WD_W`. When that stage runs out, a sticky time-out flag is set. The flag can pull an active-low interrupt pin, which is held low until software clears the watchdog or masks the interrupt.

All control arrives as one-cycle command strobes from a command decoder, which lies outside this block. Three independent controls each have an enable and a disable strobe: the timer, the watchdog and the interrupt. The timer and the watchdog also have clear strobes. A system-disable strobe freezes the prescaler, but only while the internal clock source is selected. With the external clock selected it is ignored. Every pin is a plain level or a single-cycle pulse, and no pin has flow control.

Top module: `tick_watchdog_unit`

## Requirements
- R1: After reset, tb_tick=0, wdt_timeout=0, irq_n=1 and sys_on=1, and the timer, watchdog and interrupt enables are all off.
- R2: While sys_on=1, each cycle with src_tick=1 advances the shared prescaler by one. The prescaler carries on every `2**PRE_W`-th such tick, whether the timer and watchdog are enabled or not.
- R3: tb_tick is high for exactly the one cycle after a carry, and only if the timer was enabled before that carry. A disabled timer suppresses the pulse while the prescaler keeps counting.
- R4: cmd_tmr_clr zeroes the prescaler and cancels a pending tb_tick. Counting restarts, so the next pulse follows the next full `2**PRE_W` ticks. It leaves the watchdog stage and wdt_timeout untouched.
- R5: With the watchdog enabled, wdt_timeout rises in the cycle after the `2**WD_W`-th carry counted since the last cmd_wdt_clr. With the default parameters this is 1024 source ticks.
- R6: wdt_timeout stays set until cmd_wdt_clr. cmd_wdt_clr also zeroes the watchdog stage. No other command clears the flag.
- R7: irq_n is low exactly when wdt_timeout=1 and the interrupt is enabled. cmd_irq_dis returns irq_n high at once without clearing wdt_timeout, and a later cmd_irq_en drives it low again.
- R8: While the watchdog is disabled, its stage ignores carries and no time-out can be set. Progress made before the disable is kept.
- R9: For each of the three controls, a disable strobe wins over an enable strobe in the same cycle. The strobes of one control never change either of the other two.
- R10: cmd_sys_dis with ext_clk_sel=0 clears sys_on until reset. From then on, source ticks are ignored and no pulse or time-out is produced. Clear commands still act.
- R11: cmd_sys_dis with ext_clk_sel=1 has no effect, and sys_on stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_tick | input | 1 | One-cycle tick from the clock source |
| ext_clk_sel | input | 1 | 1 when an external clock is the system clock source |
| cmd_tmr_en | input | 1 | Timer enable strobe |
| cmd_tmr_dis | input | 1 | Timer disable strobe |
| cmd_tmr_clr | input | 1 | Timer clear strobe (prescaler and pulse stage) |
| cmd_wdt_en | input | 1 | Watchdog enable strobe |
| cmd_wdt_dis | input | 1 | Watchdog disable strobe |
| cmd_wdt_clr | input | 1 | Watchdog clear strobe (stage and time-out flag) |
| cmd_irq_en | input | 1 | Interrupt enable strobe |
| cmd_irq_dis | input | 1 | Interrupt disable strobe |
| cmd_sys_dis | input | 1 | System disable strobe |
| irq_n | output | 1 | Interrupt pin, active low |
| tb_tick | output | 1 | One-cycle time-base pulse |
| wdt_timeout | output | 1 | Latched watchdog time-out flag |
| sys_on | output | 1 | 1 while the prescaler is allowed to run |

## Verification
The bench builds the unit with PRE_W=3 and WD_W=2. This gives a time-base period of 8 source ticks and a watchdog period of 32, so every prescaler phase and every watchdog stage value is visited many times within a few thousand cycles. At that size the bench can run a long pseudo-random mix of ticks and command strobes, including colliding strobes, against an arithmetic model. It can also time the exact tick count to each pulse and to the time-out, which would take 1024 ticks per time-out with the default parameters.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  // index of each independently controlled function
  typedef enum logic [1:0] {
    CH_TMR = 2'd0,
    CH_WDT = 2'd1,
    CH_IRQ = 2'd2
  } ctl_ch_e;

  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_stb,
  input  logic [NUM_CH-1:0] dis_stb,
  input  logic              sys_dis_stb,
  input  logic              ext_clk_sel,
  output logic [NUM_CH-1:0] on_q,
  output logic              sys_on_q
);

  // one enable flag per control; disable has priority
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    logic flag_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_r <= 1'b0;
      else if (dis_stb[g]) flag_r <= 1'b0;
      else if (en_stb[g])  flag_r <= 1'b1;
    end
    assign on_q[g] = flag_r;

    a_r9_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb[g] |=> !on_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sys_on_q <= 1'b1;
    else if (sys_dis_stb && !ext_clk_sel) sys_on_q <= 1'b0;
  end

  a_r11_ext_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_sel && sys_on_q) |=> sys_on_q);

endmodule

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_tick,
  input  logic clr,
  input  logic tmr_on,
  output logic carry,
  output logic tick_q
);

  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt_q;
  logic             adv;

  assign adv   = run && src_tick && !clr;
  assign carry = adv && (cnt_q == PRE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (adv) cnt_q <= cnt_q + 1'b1;
      tick_q <= carry && tmr_on;
    end
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_tick && !clr && cnt_q == PRE_MAX) |=> (cnt_q == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !tick_q));

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int unsigned WD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carry,
  input  logic wdt_on,
  input  logic clr,
  output logic timeout_q
);

  localparam logic [WD_W-1:0] WD_MAX = {WD_W{1'b1}};

  logic [WD_W-1:0] stage_q;
  logic            step;

  assign step = carry && wdt_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      timeout_q <= 1'b0;
    end else if (clr) begin
      stage_q   <= '0;
      timeout_q <= 1'b0;
    end else if (step) begin
      stage_q <= stage_q + 1'b1;
      if (stage_q == WD_MAX) timeout_q <= 1'b1;
    end
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q && !clr) |=> timeout_q);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_on && !clr) |=> ($stable(stage_q) && $stable(timeout_q)));

endmodule

// File: rtl/tick_watchdog_unit.sv
module tick_watchdog_unit
  import tbw_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned WD_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_tick,
  input  logic ext_clk_sel,
  input  logic cmd_tmr_en,
  input  logic cmd_tmr_dis,
  input  logic cmd_tmr_clr,
  input  logic cmd_wdt_en,
  input  logic cmd_wdt_dis,
  input  logic cmd_wdt_clr,
  input  logic cmd_irq_en,
  input  logic cmd_irq_dis,
  input  logic cmd_sys_dis,
  output logic irq_n,
  output logic tb_tick,
  output logic wdt_timeout,
  output logic sys_on
);

  logic [NUM_CH-1:0] en_stb;
  logic [NUM_CH-1:0] dis_stb;
  logic [NUM_CH-1:0] on_q;
  logic              carry;

  assign en_stb[CH_TMR]  = cmd_tmr_en;
  assign en_stb[CH_WDT]  = cmd_wdt_en;
  assign en_stb[CH_IRQ]  = cmd_irq_en;
  assign dis_stb[CH_TMR] = cmd_tmr_dis;
  assign dis_stb[CH_WDT] = cmd_wdt_dis;
  assign dis_stb[CH_IRQ] = cmd_irq_dis;

  tbw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_stb      (en_stb),
    .dis_stb     (dis_stb),
    .sys_dis_stb (cmd_sys_dis),
    .ext_clk_sel (ext_clk_sel),
    .on_q        (on_q),
    .sys_on_q    (sys_on)
  );

  tbw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sys_on),
    .src_tick (src_tick),
    .clr      (cmd_tmr_clr),
    .tmr_on   (on_q[CH_TMR]),
    .carry    (carry),
    .tick_q   (tb_tick)
  );

  tbw_watchdog #(.WD_W(WD_W)) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .carry     (carry),
    .wdt_on    (on_q[CH_WDT]),
    .clr       (cmd_wdt_clr),
    .timeout_q (wdt_timeout)
  );

  // interrupt pin: active low, masked by the interrupt enable
  assign irq_n = !(wdt_timeout && on_q[CH_IRQ]);

  a_r7_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !cmd_wdt_clr && !cmd_irq_dis) |=> !irq_n);

  a_r7_dis_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_dis |=> irq_n);

  a_r3_tick_needs_timer: assert property (@(posedge clk) disable iff (!rst_n)
    tb_tick |-> $past(on_q[CH_TMR]));

endmodule

// File: tb/test_tick_watchdog_unit.sv
module test_tick_watchdog_unit;
  localparam int PRE_W = 3;
  localparam int WD_W  = 2;
  localparam int PMOD  = 1 << PRE_W;
  localparam int WMOD  = 1 << WD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_tick = 0, ext_clk_sel = 0;
  logic cmd_tmr_en = 0, cmd_tmr_dis = 0, cmd_tmr_clr = 0;
  logic cmd_wdt_en = 0, cmd_wdt_dis = 0, cmd_wdt_clr = 0;
  logic cmd_irq_en = 0, cmd_irq_dis = 0, cmd_sys_dis = 0;
  logic irq_n, tb_tick, wdt_timeout, sys_on;

  always #4 clk = ~clk;

  tick_watchdog_unit #(.PRE_W(PRE_W), .WD_W(WD_W)) i_tick_watchdog_unit (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_clk_sel(ext_clk_sel),
    .cmd_tmr_en(cmd_tmr_en), .cmd_tmr_dis(cmd_tmr_dis), .cmd_tmr_clr(cmd_tmr_clr),
    .cmd_wdt_en(cmd_wdt_en), .cmd_wdt_dis(cmd_wdt_dis), .cmd_wdt_clr(cmd_wdt_clr),
    .cmd_irq_en(cmd_irq_en), .cmd_irq_dis(cmd_irq_dis), .cmd_sys_dis(cmd_sys_dis),
    .irq_n(irq_n), .tb_tick(tb_tick), .wdt_timeout(wdt_timeout), .sys_on(sys_on)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference state, from the requirements
  int m_ticks = 0;   // source ticks since timer clear, while running
  int m_carr  = 0;   // carries counted by the watchdog since its clear
  bit m_tmr = 0, m_wdt = 0, m_irq = 0, m_sys = 1, m_to = 0, m_tb = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    bit carry;
    carry = m_sys && src_tick && !cmd_tmr_clr && ((m_ticks % PMOD) == PMOD - 1);
    if (cmd_tmr_clr) begin
      m_ticks = 0; m_tb = 0;
    end else begin
      if (m_sys && src_tick) m_ticks++;
      m_tb = carry && m_tmr;
    end
    if (cmd_wdt_clr) begin
      m_carr = 0; m_to = 0;
    end else if (carry && m_wdt) begin
      m_carr++;
      if (m_carr % WMOD == 0) m_to = 1;
    end
    if (cmd_tmr_dis) m_tmr = 0; else if (cmd_tmr_en) m_tmr = 1;
    if (cmd_wdt_dis) m_wdt = 0; else if (cmd_wdt_en) m_wdt = 1;
    if (cmd_irq_dis) m_irq = 0; else if (cmd_irq_en) m_irq = 1;
    if (cmd_sys_dis && !ext_clk_sel) m_sys = 0;
  endtask

  task automatic clear_strobes();
    src_tick = 0;
    cmd_tmr_en = 0; cmd_tmr_dis = 0; cmd_tmr_clr = 0;
    cmd_wdt_en = 0; cmd_wdt_dis = 0; cmd_wdt_clr = 0;
    cmd_irq_en = 0; cmd_irq_dis = 0; cmd_sys_dis = 0;
  endtask

  // one clock: inputs were set at the falling edge, compare at the next one
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    chk(tb_tick == m_tb, "R3 tb_tick", tb_tick, m_tb);
    chk(wdt_timeout == m_to, "R5 wdt_timeout", wdt_timeout, m_to);
    chk(irq_n == !(m_to && m_irq), "R7 irq_n", irq_n, !(m_to && m_irq));
    chk(sys_on == m_sys, "R10 sys_on", sys_on, m_sys);
    clear_strobes();
  endtask

  task automatic run_src(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      src_tick = 1; step();
      for (int j = 0; j < gap; j++) step();
    end
  endtask

  initial begin : watchdog_timer
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    int cnt;
    logic [15:0] lfsr;
    @(negedge clk);
    chk(irq_n == 1 && tb_tick == 0 && wdt_timeout == 0 && sys_on == 1,
        "R1 reset outputs", {irq_n, tb_tick, wdt_timeout, sys_on}, 4'b1001);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: timer enabled, ticks every cycle, then sparse ticks
    cmd_tmr_en = 1; step();
    cnt = 0;
    for (int i = 1; i <= 3 * PMOD; i++) begin
      src_tick = 1; step();
      if (tb_tick) begin
        cnt++;
        chk(i % PMOD == 0, "R2 pulse position", i, (i / PMOD) * PMOD);
      end
    end
    chk(cnt == 3, "R2 pulse count", cnt, 3);
    run_src(3 * PMOD, 2);

    // R3: timer disabled suppresses pulses but prescaler keeps counting
    cmd_tmr_dis = 1; step();
    cnt = 0;
    for (int i = 0; i < 2 * PMOD; i++) begin
      src_tick = 1; step(); if (tb_tick) cnt++;
    end
    chk(cnt == 0, "R3 no pulse while disabled", cnt, 0);

    // R4: clear restarts the period
    cmd_tmr_en = 1; step();
    run_src(3, 0);
    cmd_tmr_clr = 1; step();
    cnt = 0;
    for (int i = 1; i <= PMOD; i++) begin
      src_tick = 1; step(); if (tb_tick) cnt = i;
    end
    chk(cnt == PMOD, "R4 pulse after full period from clear", cnt, PMOD);

    // R5: time-out after PMOD*WMOD ticks from watchdog clear
    cmd_tmr_clr = 1; cmd_wdt_clr = 1; cmd_wdt_en = 1; cmd_irq_en = 1; step();
    cnt = 0;
    while (!wdt_timeout && cnt < 4 * PMOD * WMOD) begin
      src_tick = 1; step(); cnt++;
    end
    chk(cnt == PMOD * WMOD, "R5 ticks to time-out", cnt, PMOD * WMOD);
    chk(irq_n == 0, "R7 irq low on time-out", irq_n, 0);

    // R4/R6: timer clear leaves the flag; only watchdog clear drops it
    cmd_tmr_clr = 1; step();
    chk(wdt_timeout == 1, "R4 timer clear keeps time-out", wdt_timeout, 1);
    cmd_tmr_dis = 1; cmd_wdt_dis = 1; step();
    chk(wdt_timeout == 1, "R6 flag survives disables", wdt_timeout, 1);
    cmd_irq_dis = 1; step();
    chk(irq_n == 1 && wdt_timeout == 1, "R7 mask releases pin, flag kept",
        {irq_n, wdt_timeout}, 2'b11);
    cmd_irq_en = 1; step();
    chk(irq_n == 0, "R7 re-enable drives pin low", irq_n, 0);
    cmd_wdt_clr = 1; step();
    chk(wdt_timeout == 0 && irq_n == 1, "R6 watchdog clear", {wdt_timeout, irq_n}, 2'b01);

    // R8: watchdog disabled, no time-out; progress kept
    cmd_wdt_en = 1; step();
    run_src(2 * PMOD, 0);
    cmd_wdt_dis = 1; step();
    run_src(8 * PMOD * WMOD, 0);
    chk(wdt_timeout == 0, "R8 no time-out while disabled", wdt_timeout, 0);
    cmd_wdt_en = 1; step();
    cnt = 0;
    while (!wdt_timeout && cnt < 4 * PMOD * WMOD) begin
      src_tick = 1; step(); cnt++;
    end
    chk(cnt == (WMOD - 2) * PMOD, "R8 stage progress kept", cnt, (WMOD - 2) * PMOD);

    // R9: disable wins over enable, controls independent
    cmd_irq_en = 1; cmd_irq_dis = 1; cmd_tmr_en = 1; step();
    chk(irq_n == 1, "R9 irq dis wins", irq_n, 1);
    cmd_irq_en = 1; step();
    chk(irq_n == 0, "R9 irq alone enabled", irq_n, 0);
    cmd_wdt_clr = 1; cmd_tmr_clr = 1; step();

    // pseudo-random sweep over ticks and strobes
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_tick = lfsr[0] | lfsr[1];
      ext_clk_sel = lfsr[2];
      if (lfsr[15:12] == 4'd0) begin
        case (lfsr[11:8])
          4'd0: cmd_tmr_en = 1;
          4'd1: cmd_tmr_dis = 1;
          4'd2: cmd_tmr_clr = 1;
          4'd3: cmd_wdt_en = 1;
          4'd4: cmd_wdt_dis = 1;
          4'd5: cmd_wdt_clr = 1;
          4'd6: cmd_irq_en = 1;
          4'd7: cmd_irq_dis = 1;
          4'd8: begin cmd_sys_dis = 1; ext_clk_sel = 1; end
          4'd9: begin cmd_wdt_en = 1; cmd_wdt_dis = 1; end
          4'd10: begin cmd_tmr_en = 1; cmd_tmr_dis = 1; end
          default: cmd_wdt_en = 1;
        endcase
      end
      step();
    end

    // R11: ignored with external clock
    ext_clk_sel = 1; cmd_sys_dis = 1; step();
    chk(sys_on == 1, "R11 external clock keeps running", sys_on, 1);

    // R10: stop with internal clock, ticks ignored
    ext_clk_sel = 0;
    cmd_tmr_en = 1; cmd_wdt_en = 1; cmd_irq_en = 1; cmd_tmr_clr = 1; cmd_wdt_clr = 1; step();
    cmd_sys_dis = 1; step();
    chk(sys_on == 0, "R10 internal clock stops", sys_on, 0);
    cnt = 0;
    for (int i = 0; i < 4 * PMOD * WMOD; i++) begin
      src_tick = 1; step(); if (tb_tick || wdt_timeout) cnt++;
    end
    chk(cnt == 0, "R10 frozen, no events", cnt, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule